// File: doc/BRIEF.md
# Parallel NOR Flash Program/Erase Sequencer

This block sits on the processor side of a byte-wide parallel NOR flash bus. It accepts one request at a time. A request is a single read, a byte program, a sector erase or a whole-chip erase. For each operation it issues the unlock and command write cycles, then reads the target location over and over until the flash reports that its internal operation is complete. No ready pin is used. Completion is found either by watching the data-complement bit or by watching the alternating status bit. The choice is made per request.

Every bus cycle has the same three phases: setup, strobe and recovery. Each phase lasts a parameter number of clock cycles. In a write cycle the write strobe is pulsed. In a read cycle the output enable is pulsed. The flash stays selected during setup and strobe and is deselected during recovery. A timeout guards the polling loop. If the timeout expires, the sequencer writes the read-mode command to return the flash to a known state, then answers with an error.

Top module: `nor_prog_seq`

## Requirements
- R1: A request with `reqOp`=01 (program) emits exactly four writes, in this order: AAh to address 5555h, 55h to 2AAAh, A0h to 5555h, then `reqData` to `reqAddr`.
- R2: A request with `reqOp`=10 (sector erase) emits six writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at `reqAddr`.
- R3: A request with `reqOp`=11 (chip erase) emits the same first five writes as R2, and its sixth write is 10h@5555h.
- R4: In every write cycle, `flWeN` is low for exactly PULSE_CYC clocks. During that time `flCeN` is low and `flDoe` is high, and `flAddr` and `flDout` stay stable. `flWeN` then stays high through a recovery phase before the next write.
- R5: In every read cycle, `flCeN` and `flOeN` are low while `flWeN` is high. `flOeN` and `flWeN` are never low together. `flOeN` returns high for at least one clock between reads.
- R6: With `reqToggle`=0, polling reads the target address until bit 7 of the read byte equals bit 7 of `reqData` for a program, or equals 1 for an erase. The response then comes with `rspError`=0 and `rspData` set to that final byte.
- R7: With `reqToggle`=1, polling ends at the first read whose bit 6 equals bit 6 of the previous read in the same request.
- R8: If completion is not seen within TIMEOUT_CYC clocks of acceptance, the sequencer writes F0h to 5555h and then responds with `rspDone`=1 and `rspError`=1.
- R9: `busy` rises on the cycle after a request is accepted and falls after the one-cycle `rspDone`. A `reqValid` raised while `busy` is high is ignored: it produces no bus cycle and no response.
- R10: A request with `reqOp`=00 (read) performs exactly one read cycle and no writes. It returns the byte in `rspData` with `rspError`=0.
- R11: While reset is asserted, `flCeN`, `flOeN` and `flWeN` are high, and `flDoe`, `busy` and `rspDone` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqOp | input | 2 | 00 read, 01 program, 10 sector erase, 11 chip erase |
| reqAddr | input | ADDR_W | Target byte address (sector address for erase) |
| reqData | input | 8 | Byte to program |
| reqToggle | input | 1 | 1: toggle-bit polling, 0: data-bit polling |
| busy | output | 1 | A request is in progress |
| rspDone | output | 1 | One-cycle completion pulse |
| rspError | output | 1 | Completion was a timeout, valid with rspDone |
| rspData | output | 8 | Last byte read from the flash |
| flAddr | output | ADDR_W | Flash address bus |
| flDout | output | 8 | Flash write data |
| flDoe | output | 1 | Data bus drive enable |
| flDin | input | 8 | Flash read data |
| flCeN | output | 1 | Flash chip enable, active low |
| flOeN | output | 1 | Flash output enable, active low |
| flWeN | output | 1 | Flash write enable, active low |

## Verification
A wrong command step index shows up as a mismatched address/data pair. It appears on the very next write-strobe rising edge, so the write scoreboard catches it within one bus cycle. A wrong poll decision or a lost previous-bit register has two possible effects. It may change the number of read strobes before `rspDone`, which the bench counts per request. Or it may stall the request until the timeout turns it into a spurious `rspError` and an extra F0h write. Bus-phase counter faults distort the strobe width or overlap the strobes within the same bus cycle.

// File: rtl/nps_pkg.sv
package nps_pkg;

  typedef enum logic [1:0] {
    OP_READ = 2'b00,
    OP_PROG = 2'b01,
    OP_SECT = 2'b10,
    OP_CHIP = 2'b11
  } opE;

  // Strobes from control to datapath
  typedef struct packed {
    logic       latchReq;
    logic       clrTimer;
    logic       startWr;
    logic       startRd;
    logic       recover;
    logic       savePrev;
    logic [2:0] step;
  } strobeT;

  localparam logic [15:0] UNLOCK_HI = 16'h5555;
  localparam logic [15:0] UNLOCK_LO = 16'h2AAA;
  localparam logic [7:0]  READ_MODE_CMD = 8'hF0;

  function automatic logic [2:0] lastStep(opE op);
    return (op == OP_PROG) ? 3'd3 : 3'd5;
  endfunction

  function automatic logic usesTarget(opE op, logic [2:0] step);
    return (op == OP_PROG && step == 3'd3) || (op == OP_SECT && step == 3'd5);
  endfunction

  function automatic logic [15:0] constAddr(logic [2:0] step);
    return (step == 3'd1 || step == 3'd4) ? UNLOCK_LO : UNLOCK_HI;
  endfunction

  function automatic logic [7:0] cmdByte(opE op, logic [2:0] step, logic [7:0] d);
    logic [7:0] b;
    case (step)
      3'd0:    b = 8'hAA;
      3'd1:    b = 8'h55;
      3'd2:    b = (op == OP_PROG) ? 8'hA0 : 8'h80;
      3'd3:    b = (op == OP_PROG) ? d : 8'hAA;
      3'd4:    b = 8'h55;
      default: b = (op == OP_SECT) ? 8'h30 : 8'h10;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/nps_dpath.sv
module nps_dpath
  import nps_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 3,
  parameter int HOLD_CYC    = 2,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic              reqToggle,
  input  logic [7:0]        flDin,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flDout,
  output logic              flDoe,
  output logic              flCeN,
  output logic              flOeN,
  output logic              flWeN,
  output logic              cycDone,
  output logic              pollMet,
  output logic              timeoutHit,
  output opE                opQ,
  output logic [7:0]        rdByte
);

  localparam int PH_MAX = (SETUP_CYC > PULSE_CYC) ?
                          ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                          ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int CNT_W  = $clog2(PH_MAX + 1);
  localparam int TMR_W  = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phaseE;

  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        dataQ;
  logic              togQ;
  logic [ADDR_W-1:0] busAddr;
  logic [7:0]        busData;
  logic              isRd;
  phaseE             phase;
  logic [CNT_W-1:0]  cnt;
  logic              prevBit6;
  logic              havePrev;
  logic [TMR_W-1:0]  tmr;
  logic [ADDR_W-1:0] nextAddr;
  logic [7:0]        nextData;
  logic              expBit;

  // Request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ   <= OP_READ;
      addrQ <= '0;
      dataQ <= '0;
      togQ  <= 1'b0;
    end else if (strobe.latchReq) begin
      opQ   <= opE'(reqOp);
      addrQ <= reqAddr;
      dataQ <= reqData;
      togQ  <= reqToggle;
    end
  end

  // Bus cycle content selection
  always_comb begin
    if (strobe.recover) begin
      nextAddr = ADDR_W'(UNLOCK_HI);
      nextData = READ_MODE_CMD;
    end else if (strobe.startRd || usesTarget(opQ, strobe.step)) begin
      nextAddr = addrQ;
      nextData = cmdByte(opQ, strobe.step, dataQ);
    end else begin
      nextAddr = ADDR_W'(constAddr(strobe.step));
      nextData = cmdByte(opQ, strobe.step, dataQ);
    end
  end

  // Three-phase bus cycle engine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      busAddr <= '0;
      busData <= '0;
      isRd    <= 1'b0;
      rdByte  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (strobe.startWr || strobe.startRd) begin
          busAddr <= nextAddr;
          busData <= nextData;
          isRd    <= strobe.startRd;
          phase   <= PH_SETUP;
          cnt     <= CNT_W'(SETUP_CYC - 1);
        end
        PH_SETUP: if (cnt == '0) begin
          phase <= PH_PULSE;
          cnt   <= CNT_W'(PULSE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        PH_PULSE: if (cnt == '0) begin
          if (isRd) rdByte <= flDin;
          phase <= PH_HOLD;
          cnt   <= CNT_W'(HOLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) phase <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign cycDone = (phase == PH_HOLD) && (cnt == '0);
  assign flCeN   = !((phase == PH_SETUP) || (phase == PH_PULSE));
  assign flWeN   = !((phase == PH_PULSE) && !isRd);
  assign flOeN   = !((phase == PH_PULSE) && isRd);
  assign flDoe   = !isRd && ((phase == PH_SETUP) || (phase == PH_PULSE));
  assign flAddr  = busAddr;
  assign flDout  = busData;

  // Completion evaluation
  always_ff @(posedge clk) begin
    if (!rstN || strobe.latchReq) begin
      prevBit6 <= 1'b0;
      havePrev <= 1'b0;
    end else if (strobe.savePrev) begin
      prevBit6 <= rdByte[6];
      havePrev <= 1'b1;
    end
  end

  assign expBit = (opQ == OP_PROG) ? dataQ[7] : 1'b1;

  always_comb begin
    if (opQ == OP_READ)  pollMet = 1'b1;
    else if (togQ)       pollMet = havePrev && (rdByte[6] == prevBit6);
    else                 pollMet = (rdByte[7] == expBit);
  end

  // Timeout measured from acceptance
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrTimer) tmr <= '0;
    else if (!timeoutHit)         tmr <= tmr + 1'b1;
  end

  assign timeoutHit = (tmr >= TMR_W'(TIMEOUT_CYC));

endmodule

// File: rtl/nps_ctrl.sv
module nps_ctrl
  import nps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       cycDone,
  input  logic       pollMet,
  input  logic       timeoutHit,
  input  opE         opQ,
  output strobeT     strobe,
  output logic       busy,
  output logic       rspDone,
  output logic       rspError
);

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_CMDW, S_RD, S_RDW, S_REC, S_RECW, S_RESP
  } stateE;

  stateE      state;
  logic [2:0] step;
  logic       errQ;

  always_comb begin
    strobe      = '0;
    strobe.step = step;
    case (state)
      S_IDLE: if (reqValid) begin
        strobe.latchReq = 1'b1;
        strobe.clrTimer = 1'b1;
      end
      S_CMD:  strobe.startWr = 1'b1;
      S_RD:   strobe.startRd = 1'b1;
      S_RDW:  strobe.savePrev = cycDone && !pollMet;
      S_REC: begin
        strobe.startWr = 1'b1;
        strobe.recover = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      step  <= '0;
      errQ  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          errQ  <= 1'b0;
          step  <= '0;
          state <= (opE'(reqOp) == OP_READ) ? S_RD : S_CMD;
        end
        S_CMD:  state <= S_CMDW;
        S_CMDW: if (cycDone) begin
          if (step == lastStep(opQ)) state <= S_RD;
          else begin
            step  <= step + 1'b1;
            state <= S_CMD;
          end
        end
        S_RD:   state <= S_RDW;
        S_RDW:  if (cycDone) begin
          if (pollMet)         state <= S_RESP;
          else if (timeoutHit) state <= S_REC;
          else                 state <= S_RD;
        end
        S_REC:  state <= S_RECW;
        S_RECW: if (cycDone) begin
          errQ  <= 1'b1;
          state <= S_RESP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign rspDone  = (state == S_RESP);
  assign rspError = (state == S_RESP) && errQ;

endmodule

// File: rtl/nor_prog_seq.sv
module nor_prog_seq
  import nps_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 3,
  parameter int HOLD_CYC    = 2,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqData,
  input  logic              reqToggle,
  output logic              busy,
  output logic              rspDone,
  output logic              rspError,
  output logic [7:0]        rspData,
  output logic [ADDR_W-1:0] flAddr,
  output logic [7:0]        flDout,
  output logic              flDoe,
  input  logic [7:0]        flDin,
  output logic              flCeN,
  output logic              flOeN,
  output logic              flWeN
);

  strobeT strobe;
  logic   cycDone;
  logic   pollMet;
  logic   timeoutHit;
  opE     opQ;

  nps_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .cycDone(cycDone), .pollMet(pollMet), .timeoutHit(timeoutHit),
    .opQ(opQ), .strobe(strobe), .busy(busy), .rspDone(rspDone),
    .rspError(rspError)
  );

  nps_dpath #(
    .ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .reqToggle(reqToggle),
    .flDin(flDin), .flAddr(flAddr), .flDout(flDout), .flDoe(flDoe),
    .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN), .cycDone(cycDone),
    .pollMet(pollMet), .timeoutHit(timeoutHit), .opQ(opQ), .rdByte(rspData)
  );

endmodule

// File: rtl/nps_checker.sv
module nps_checker #(
  parameter int ADDR_W    = 17,
  parameter int PULSE_CYC = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              rspDone,
  input logic              rspError,
  input logic [ADDR_W-1:0] flAddr,
  input logic [7:0]        flDout,
  input logic              flDoe,
  input logic              flCeN,
  input logic              flOeN,
  input logic              flWeN
);

  int weLow;

  always_ff @(posedge clk) begin
    if (!rstN)      weLow <= 0;
    else if (flWeN) weLow <= 0;
    else            weLow <= weLow + 1;
  end

  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(!flOeN && !flWeN));

  a_r4_ce_covers: assert property (@(posedge clk) disable iff (!rstN)
    (!flWeN || !flOeN) |-> !flCeN);

  a_r4_drive_on_we: assert property (@(posedge clk) disable iff (!rstN)
    !flWeN |-> flDoe);

  a_r4_stable_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (!flWeN && $past(!flWeN)) |-> ($stable(flAddr) && $stable(flDout)));

  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flWeN) |-> (weLow == PULSE_CYC));

  a_r5_oe_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flOeN) |=> flOeN);

  a_r9_done_busy: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> busy);

  a_r9_accept: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    rspError |-> rspDone);

endmodule

bind nor_prog_seq nps_checker #(.ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy),
  .rspDone(rspDone), .rspError(rspError), .flAddr(flAddr), .flDout(flDout),
  .flDoe(flDoe), .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN)
);

// File: tb/sim_nor_prog_seq.sv
`timescale 1ns/1ps
module sim_nor_prog_seq;

  localparam int AW = 17;
  localparam int SU = 2;
  localparam int PW = 3;
  localparam int HD = 2;
  localparam int TO = 3000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqOp = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0]    reqData = '0;
  logic          reqToggle = 1'b0;
  logic          busy, rspDone, rspError;
  logic [7:0]    rspData;
  logic [AW-1:0] flAddr;
  logic [7:0]    flDout, flDin;
  logic          flDoe, flCeN, flOeN, flWeN;

  always #2 clk = ~clk;

  nor_prog_seq #(.ADDR_W(AW), .SETUP_CYC(SU), .PULSE_CYC(PW), .HOLD_CYC(HD),
                 .TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .reqToggle(reqToggle),
    .busy(busy), .rspDone(rspDone), .rspError(rspError), .rspData(rspData),
    .flAddr(flAddr), .flDout(flDout), .flDoe(flDoe), .flDin(flDin),
    .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN)
  );

  int    nChecks = 0;
  int    nFail = 0;
  string curTag = "";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Status engine standing in for the flash
  logic [7:0] modelData = 8'hFF;
  int         pending = 0;
  bit         tog = 1'b0;
  int         readCnt = 0;
  bit         armed = 1'b0;
  time        tFall = 0;
  logic [AW+7:0] expQ[$];

  assign flDin = (pending > 0) ? {~modelData[7], tog, modelData[5:0]} : modelData;

  always @(negedge flOeN) if (armed) begin
    readCnt++;
    chk(flWeN && !flCeN, "R5", "read strobe with CE low and WE high",
        {30'd0, flWeN, flCeN}, 32'h2);
  end

  always @(posedge flOeN) if (armed && pending > 0) begin
    pending--;
    tog = ~tog;
  end

  always @(negedge flWeN) tFall = $time;

  // Monitor: pop expected writes as they appear on the bus
  always @(posedge flWeN) if (armed) begin
    logic [AW+7:0] e;
    chk(($time - tFall) == PW * 4, "R4", "write strobe width ns",
        32'($time - tFall), 32'(PW * 4));
    if (expQ.size() == 0) begin
      chk(1'b0, "R9", "unexpected write", {7'd0, flAddr, flDout}, 32'd0);
    end else begin
      e = expQ.pop_front();
      chk({flAddr, flDout} == e, curTag, "write addr/data",
          {7'd0, flAddr, flDout}, {7'd0, e});
    end
  end

  // Driver: push expected writes, issue request, check response
  task automatic doReq(input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [7:0] d, input bit tg, input int pend,
                       input logic [7:0] md, input bit expErr,
                       input int expReads, input string tag);
    modelData = md;
    pending   = pend;
    tog       = 1'b0;
    readCnt   = 0;
    curTag    = tag;
    if (op != 2'b00) begin
      expQ.push_back({AW'(17'h05555), 8'hAA});
      expQ.push_back({AW'(17'h02AAA), 8'h55});
      if (op == 2'b01) begin
        expQ.push_back({AW'(17'h05555), 8'hA0});
        expQ.push_back({a, d});
      end else begin
        expQ.push_back({AW'(17'h05555), 8'h80});
        expQ.push_back({AW'(17'h05555), 8'hAA});
        expQ.push_back({AW'(17'h02AAA), 8'h55});
        if (op == 2'b10) expQ.push_back({a, 8'h30});
        else             expQ.push_back({AW'(17'h05555), 8'h10});
      end
    end
    if (expErr) expQ.push_back({AW'(17'h05555), 8'hF0});
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqData = d; reqToggle = tg;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy, "R9", "busy after accept", {31'd0, busy}, 32'd1);
    do @(negedge clk); while (!rspDone);
    chk(rspError == expErr, expErr ? "R8" : tag, "rspError",
        {31'd0, rspError}, {31'd0, expErr});
    if (!expErr)
      chk(rspData == md, tag, "rspData", {24'd0, rspData}, {24'd0, md});
    if (expReads >= 0)
      chk(readCnt == expReads, tag, "read count", 32'(readCnt), 32'(expReads));
    chk(expQ.size() == 0, tag, "writes left over", 32'(expQ.size()), 32'd0);
    @(negedge clk);
    chk(!busy, "R9", "idle after response", {31'd0, busy}, 32'd0);
    pending = 0;
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11 reset state
    chk(flCeN && flOeN && flWeN, "R11", "strobes high in reset",
        {29'd0, flCeN, flOeN, flWeN}, 32'h7);
    chk(!flDoe, "R11", "no drive in reset", {31'd0, flDoe}, 32'd0);
    chk(!busy && !rspDone, "R11", "idle in reset", {30'd0, busy, rspDone}, 32'd0);
    rstN = 1'b1;
    armed = 1'b1;
    @(negedge clk);

    // R1 + R6: program, data polling, bit7=1, three busy reads
    doReq(2'b01, 17'h12345, 8'hC3, 1'b0, 3, 8'hC3, 1'b0, 4, "R1");
    // R6: program with bit7=0, completes on first read
    doReq(2'b01, 17'h00100, 8'h3C, 1'b0, 0, 8'h3C, 1'b0, 1, "R6");
    // R2 + R6: sector erase, data polling expects bit7=1
    doReq(2'b10, 17'h0A200, 8'h00, 1'b0, 5, 8'hFF, 1'b0, 6, "R2");
    // R3 + R7: chip erase, toggle polling, reads 0,1,0,1,1
    doReq(2'b11, 17'h1FFFF, 8'h00, 1'b1, 4, 8'hFF, 1'b0, 5, "R3");
    // R7: toggle, reads 0,1,0 then true 1,1
    doReq(2'b10, 17'h04000, 8'h00, 1'b1, 3, 8'hFF, 1'b0, 5, "R7");
    // R7: toggle, no busy reads, two equal reads needed
    doReq(2'b01, 17'h00042, 8'h3C, 1'b1, 0, 8'h3C, 1'b0, 2, "R7");
    // R10: single read
    doReq(2'b00, 17'h00777, 8'h00, 1'b0, 0, 8'h5A, 1'b0, 1, "R10");

    // R9: request while busy is ignored
    fork
      doReq(2'b01, 17'h01010, 8'h81, 1'b0, 2, 8'h81, 1'b0, 3, "R9");
      begin
        repeat (12) @(negedge clk);
        reqValid = 1'b1; reqOp = 2'b11; reqAddr = 17'h00005; reqData = 8'h00;
        @(negedge clk);
        reqValid = 1'b0;
      end
    join

    // R8: never completes, timeout recovery
    doReq(2'b01, 17'h00200, 8'hC3, 1'b0, 1000000, 8'hC3, 1'b1, -1, "R8");

    repeat (10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule